// File: doc/BRIEF.md
# Multicycle Instruction Sequencer with Exception Entry

This block is the control unit of a multicycle processor core. The core uses a single memory for both code and data, one ALU and the holding registers IR, A, B, S and M. The controller is a Moore state machine. Its datapath strobes and selector codes depend only on the current state. Its next state depends on the current state, the opcode held in IR and the ALU overflow flag. The one exception is the effective PC enable, which combines a conditional PC write with the ALU zero flag.

Every instruction starts with the same two cycles. The first fetches the instruction and advances PC by 4. The second decodes it, reads the register operands and precomputes the branch target. A class-specific tail of one to three cycles follows. An undefined opcode, or an arithmetic overflow in a register-register operation, sends the machine to an exception cycle. That cycle stores PC−4 into EPC, writes a reason code and loads PC with the fixed handler vector.

Top module: `mc_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, the state is the fetch cycle. Fetch drives ir_wr=1, pc_wr=1, pc_en=1, alu_sel_b=1 (constant 4) and every other output 0.
- R2: The cycle after fetch is decode, whatever the opcode. Decode drives alu_sel_b=3 (shifted immediate), alu_sel_a=0 (PC), alu_op=0 (add) and ext_op=1, with no write strobe.
- R3: Opcode 0x00 (register-register) takes two tail cycles. The first drives alu_sel_a=1, alu_sel_b=0 and alu_op=2 (function field). The second drives reg_wr=1, reg_dst=1 and mem_to_reg=0.
- R4: Opcode 0x23 (load) takes three tail cycles. The first drives alu_sel_a=1, alu_sel_b=2 and ext_op=1. The second drives iord=1. The third drives reg_wr=1, reg_dst=0 and mem_to_reg=1.
- R5: Opcode 0x2B (store) takes the same address cycle as a load, then one cycle with mem_wr=1 and iord=1.
- R6: Opcode 0x04 (branch-equal) takes one tail cycle with pc_wr_cond=1, pc_src=1 (S), alu_sel_a=1, alu_sel_b=0 and alu_op=1 (subtract). In that cycle pc_en equals alu_zero.
- R7: Opcode 0x02 (jump) takes one tail cycle with pc_wr=1, pc_en=1 and pc_src=2 (jump target).
- R8: Any other opcode leads from decode to an exception cycle. That cycle drives epc_wr=1, cause_wr=1, cause_code=0, pc_wr=1, pc_en=1, pc_src=3 (handler vector 0x80000180), alu_sel_a=0, alu_sel_b=1 and alu_op=1, so the ALU forms PC−4. Fetch follows.
- R9: If alu_ovf is 1 in the register-register compute cycle, the write-back cycle is skipped. The next cycle is an exception cycle as in R8 but with cause_code=1, and reg_wr stays 0.
- R10: Opcode 0x10 (return from exception) takes one tail cycle with pc_wr=1, pc_en=1 and pc_src=4 (EPC).
- R11: During fetch, the opcode, alu_zero and alu_ovf have no effect on any output. cause_code is 0 whenever cause_wr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | OP_W | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result is zero |
| alu_ovf | input | 1 | ALU signed overflow |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write if the ALU result is zero |
| pc_en | output | 1 | Effective PC load enable |
| iord | output | 1 | Memory address select: 0 PC, 1 S |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| reg_dst | output | 1 | Destination select: 0 rt, 1 rd |
| reg_wr | output | 1 | Register file write |
| alu_sel_a | output | 1 | ALU A source: 0 PC, 1 A |
| alu_sel_b | output | 2 | ALU B source: 0 B, 1 four, 2 immediate, 3 immediate×4 |
| alu_op | output | 2 | 0 add, 1 subtract, 2 function field |
| pc_src | output | 3 | 0 ALU, 1 S, 2 jump target, 3 handler vector, 4 EPC |
| mem_to_reg | output | 1 | Write data: 0 S, 1 M |
| ext_op | output | 1 | Sign extension of the immediate |
| epc_wr | output | 1 | EPC load from the ALU result |
| cause_wr | output | 1 | Cause register load |
| cause_code | output | CAUSE_W | 0 undefined instruction, 1 overflow |

## Verification
The bench builds the block with its default parameters: a 6-bit opcode, a 4-bit cause code and the opcode values listed above. With these values every instruction class can be reached, including both exception causes and both branch outcomes. During fetch the bench drives a deliberately wrong opcode and raised flags. This exposes any output or next state that leaks from the inputs in that cycle. Instructions run back to back, so every class-to-fetch return path is covered.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    typedef enum logic [3:0] {
        S_FETCH, S_DECODE, S_RCOMP, S_RWB, S_MADDR, S_MREAD, S_MWB,
        S_MWRITE, S_BRANCH, S_JUMP, S_RFE, S_EXC_UND, S_EXC_OVF
    } state_e;

    typedef enum logic [2:0] {
        C_ALU, C_LOAD, C_STORE, C_BEQ, C_JUMP, C_RFE, C_UNDEF
    } iclass_e;

    localparam logic [1:0] SELB_REG  = 2'd0;
    localparam logic [1:0] SELB_FOUR = 2'd1;
    localparam logic [1:0] SELB_IMM  = 2'd2;
    localparam logic [1:0] SELB_IMM4 = 2'd3;

    localparam logic [1:0] AOP_ADD   = 2'd0;
    localparam logic [1:0] AOP_SUB   = 2'd1;
    localparam logic [1:0] AOP_FUNCT = 2'd2;

    localparam logic [2:0] PCS_ALU = 3'd0;
    localparam logic [2:0] PCS_S   = 3'd1;
    localparam logic [2:0] PCS_JMP = 3'd2;
    localparam logic [2:0] PCS_VEC = 3'd3;
    localparam logic [2:0] PCS_EPC = 3'd4;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       iord;
        logic       mem_wr;
        logic       ir_wr;
        logic       reg_dst;
        logic       reg_wr;
        logic       alu_sel_a;
        logic [1:0] alu_sel_b;
        logic [1:0] alu_op;
        logic [2:0] pc_src;
        logic       mem_to_reg;
        logic       ext_op;
        logic       epc_wr;
        logic       cause_wr;
        logic       cause_ovf;
    } ctrl_t;

endpackage

// File: rtl/mc_op_class.sv
module mc_op_class
    import mc_ctrl_pkg::*;
#(
    parameter int          OP_W   = 6,
    parameter logic [OP_W-1:0] OP_R   = 'h00,
    parameter logic [OP_W-1:0] OP_LW  = 'h23,
    parameter logic [OP_W-1:0] OP_SW  = 'h2B,
    parameter logic [OP_W-1:0] OP_BEQ = 'h04,
    parameter logic [OP_W-1:0] OP_J   = 'h02,
    parameter logic [OP_W-1:0] OP_RFE = 'h10
) (
    input  logic [OP_W-1:0] opcode,
    output iclass_e         cls
);

    always_comb begin
        if      (opcode == OP_R)   cls = C_ALU;
        else if (opcode == OP_LW)  cls = C_LOAD;
        else if (opcode == OP_SW)  cls = C_STORE;
        else if (opcode == OP_BEQ) cls = C_BEQ;
        else if (opcode == OP_J)   cls = C_JUMP;
        else if (opcode == OP_RFE) cls = C_RFE;
        else                       cls = C_UNDEF;
    end

endmodule

// File: rtl/mc_ctrl_rom.sv
module mc_ctrl_rom
    import mc_ctrl_pkg::*;
(
    input  state_e st,
    output ctrl_t  c
);

    always_comb begin
        c = '0;
        case (st)
            S_FETCH: begin
                c.ir_wr     = 1'b1;
                c.pc_wr     = 1'b1;
                c.alu_sel_b = SELB_FOUR;
                c.alu_op    = AOP_ADD;
                c.pc_src    = PCS_ALU;
            end
            S_DECODE: begin
                c.alu_sel_b = SELB_IMM4;
                c.ext_op    = 1'b1;
            end
            S_RCOMP: begin
                c.alu_sel_a = 1'b1;
                c.alu_sel_b = SELB_REG;
                c.alu_op    = AOP_FUNCT;
            end
            S_RWB: begin
                c.reg_wr  = 1'b1;
                c.reg_dst = 1'b1;
            end
            S_MADDR: begin
                c.alu_sel_a = 1'b1;
                c.alu_sel_b = SELB_IMM;
                c.ext_op    = 1'b1;
            end
            S_MREAD: begin
                c.iord = 1'b1;
            end
            S_MWB: begin
                c.reg_wr     = 1'b1;
                c.mem_to_reg = 1'b1;
            end
            S_MWRITE: begin
                c.iord   = 1'b1;
                c.mem_wr = 1'b1;
            end
            S_BRANCH: begin
                c.alu_sel_a  = 1'b1;
                c.alu_sel_b  = SELB_REG;
                c.alu_op     = AOP_SUB;
                c.pc_wr_cond = 1'b1;
                c.pc_src     = PCS_S;
            end
            S_JUMP: begin
                c.pc_wr  = 1'b1;
                c.pc_src = PCS_JMP;
            end
            S_RFE: begin
                c.pc_wr  = 1'b1;
                c.pc_src = PCS_EPC;
            end
            S_EXC_UND, S_EXC_OVF: begin
                c.alu_sel_b = SELB_FOUR;
                c.alu_op    = AOP_SUB;
                c.epc_wr    = 1'b1;
                c.cause_wr  = 1'b1;
                c.cause_ovf = (st == S_EXC_OVF);
                c.pc_wr     = 1'b1;
                c.pc_src    = PCS_VEC;
            end
            default: c = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_ctrl_pkg::*;
#(
    parameter int OP_W    = 6,
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    opcode,
    input  logic               alu_zero,
    input  logic               alu_ovf,
    output logic               pc_wr,
    output logic               pc_wr_cond,
    output logic               pc_en,
    output logic               iord,
    output logic               mem_wr,
    output logic               ir_wr,
    output logic               reg_dst,
    output logic               reg_wr,
    output logic               alu_sel_a,
    output logic [1:0]         alu_sel_b,
    output logic [1:0]         alu_op,
    output logic [2:0]         pc_src,
    output logic               mem_to_reg,
    output logic               ext_op,
    output logic               epc_wr,
    output logic               cause_wr,
    output logic [CAUSE_W-1:0] cause_code
);

    typedef struct packed {
        state_e state;
    } seq_t;

    seq_t    seq_d, seq_q;
    iclass_e cls;
    ctrl_t   ctl;

    mc_op_class #(.OP_W(OP_W)) u_cls (
        .opcode (opcode),
        .cls    (cls)
    );

    mc_ctrl_rom u_rom (
        .st (seq_q.state),
        .c  (ctl)
    );

    always_comb begin
        seq_d = seq_q;
        case (seq_q.state)
            S_FETCH:  seq_d.state = S_DECODE;
            S_DECODE: begin
                case (cls)
                    C_ALU:            seq_d.state = S_RCOMP;
                    C_LOAD, C_STORE:  seq_d.state = S_MADDR;
                    C_BEQ:            seq_d.state = S_BRANCH;
                    C_JUMP:           seq_d.state = S_JUMP;
                    C_RFE:            seq_d.state = S_RFE;
                    default:          seq_d.state = S_EXC_UND;
                endcase
            end
            S_RCOMP:  seq_d.state = alu_ovf ? S_EXC_OVF : S_RWB;
            S_MADDR:  seq_d.state = (cls == C_STORE) ? S_MWRITE : S_MREAD;
            S_MREAD:  seq_d.state = S_MWB;
            default:  seq_d.state = S_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: S_FETCH};
        else        seq_q <= seq_d;
    end

    assign pc_wr      = ctl.pc_wr;
    assign pc_wr_cond = ctl.pc_wr_cond;
    assign pc_en      = ctl.pc_wr | (ctl.pc_wr_cond & alu_zero);
    assign iord       = ctl.iord;
    assign mem_wr     = ctl.mem_wr;
    assign ir_wr      = ctl.ir_wr;
    assign reg_dst    = ctl.reg_dst;
    assign reg_wr     = ctl.reg_wr;
    assign alu_sel_a  = ctl.alu_sel_a;
    assign alu_sel_b  = ctl.alu_sel_b;
    assign alu_op     = ctl.alu_op;
    assign pc_src     = ctl.pc_src;
    assign mem_to_reg = ctl.mem_to_reg;
    assign ext_op     = ctl.ext_op;
    assign epc_wr     = ctl.epc_wr;
    assign cause_wr   = ctl.cause_wr;
    assign cause_code = CAUSE_W'(ctl.cause_ovf);

    // R2
    fetch_then_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> (!ir_wr && !pc_wr && !reg_wr && !mem_wr && ext_op));

    // R5
    store_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> iord);

    // R8
    undef_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == S_DECODE && cls == C_UNDEF) |=> (cause_wr && cause_code == '0));

    // R8
    exc_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        epc_wr |=> ir_wr);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == S_RCOMP && alu_ovf) |=> (!reg_wr && cause_wr && cause_code == CAUSE_W'(1)));

    // R11
    cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_wr |-> (cause_code == '0));

endmodule

// File: tb/sim_mc_ctrl.sv
`timescale 1ns/1ps
module sim_mc_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h00;
    logic       alu_zero = 1'b0;
    logic       alu_ovf = 1'b0;
    logic       pc_wr, pc_wr_cond, pc_en, iord, mem_wr, ir_wr, reg_dst, reg_wr;
    logic       alu_sel_a, mem_to_reg, ext_op, epc_wr, cause_wr;
    logic [1:0] alu_sel_b, alu_op;
    logic [2:0] pc_src;
    logic [3:0] cause_code;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero), .alu_ovf(alu_ovf),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_en(pc_en), .iord(iord),
        .mem_wr(mem_wr), .ir_wr(ir_wr), .reg_dst(reg_dst), .reg_wr(reg_wr),
        .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b), .alu_op(alu_op), .pc_src(pc_src),
        .mem_to_reg(mem_to_reg), .ext_op(ext_op), .epc_wr(epc_wr), .cause_wr(cause_wr),
        .cause_code(cause_code)
    );

    function automatic logic [23:0] w(input int pcw, pwc, pce, io, mw, irw, rd, rw,
                                      sa, sb, aop, psrc, m2r, ext, ew, cw, cc);
        return {pcw[0], pwc[0], pce[0], io[0], mw[0], irw[0], rd[0], rw[0], sa[0],
                sb[1:0], aop[1:0], psrc[2:0], m2r[0], ext[0], ew[0], cw[0], cc[3:0]};
    endfunction

    function automatic logic [23:0] actual();
        return {pc_wr, pc_wr_cond, pc_en, iord, mem_wr, ir_wr, reg_dst, reg_wr, alu_sel_a,
                alu_sel_b, alu_op, pc_src, mem_to_reg, ext_op, epc_wr, cause_wr, cause_code};
    endfunction

    task automatic chk(input logic [23:0] exp, input string tag);
        logic [23:0] act;
        act = actual();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected words per cycle kind, built from the requirements
    logic [23:0] wf, wd, wrc, wrw, wma, wmr, wmb, wmw, wjp, wrf;
    initial begin
        wf  = w(1,0,1,0,0,1,0,0,0,1,0,0,0,0,0,0,0);
        wd  = w(0,0,0,0,0,0,0,0,0,3,0,0,0,1,0,0,0);
        wrc = w(0,0,0,0,0,0,0,0,1,0,2,0,0,0,0,0,0);
        wrw = w(0,0,0,0,0,0,1,1,0,0,0,0,0,0,0,0,0);
        wma = w(0,0,0,0,0,0,0,0,1,2,0,0,0,1,0,0,0);
        wmr = w(0,0,0,1,0,0,0,0,0,0,0,0,0,0,0,0,0);
        wmb = w(0,0,0,0,0,0,0,1,0,0,0,0,1,0,0,0,0);
        wmw = w(0,0,0,1,1,0,0,0,0,0,0,0,0,0,0,0,0);
        wjp = w(1,0,1,0,0,0,0,0,0,0,0,2,0,0,0,0,0);
        wrf = w(1,0,1,0,0,0,0,0,0,0,0,4,0,0,0,0,0);
    end

    function automatic logic [23:0] wexc(input int c);
        return w(1,0,1,0,0,0,0,0,0,1,1,3,0,0,1,1,c);
    endfunction

    task automatic run(input logic [5:0] op, input logic z, input logic ov, input string tag);
        logic [23:0] q[$];
        string       t[$];
        q.push_back(wf);  t.push_back("R11");
        q.push_back(wd);  t.push_back("R2");
        case (op)
            6'h00: begin
                q.push_back(wrc); t.push_back("R3");
                if (ov) begin q.push_back(wexc(1)); t.push_back("R9"); end
                else    begin q.push_back(wrw);     t.push_back("R3"); end
            end
            6'h23: begin
                q.push_back(wma); t.push_back("R4");
                q.push_back(wmr); t.push_back("R4");
                q.push_back(wmb); t.push_back("R4");
            end
            6'h2B: begin
                q.push_back(wma); t.push_back("R5");
                q.push_back(wmw); t.push_back("R5");
            end
            6'h04: begin
                q.push_back(w(0,1,int'(z),0,0,0,0,0,1,0,1,1,0,0,0,0,0)); t.push_back("R6");
            end
            6'h02: begin q.push_back(wjp); t.push_back("R7"); end
            6'h10: begin q.push_back(wrf); t.push_back("R10"); end
            default: begin q.push_back(wexc(0)); t.push_back("R8"); end
        endcase
        for (int i = 0; i < q.size(); i++) begin
            @(negedge clk);
            if (i == 0) begin
                opcode   = ~op;
                alu_zero = 1'b1;
                alu_ovf  = 1'b1;
            end else begin
                opcode   = op;
                alu_zero = z;
                alu_ovf  = ov;
            end
            #1 chk(q[i], {t[i], " ", tag});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 chk(wf, "R1 in reset");
        @(posedge clk);
        #1 rst_n = 1'b1;
        run(6'h00, 1'b0, 1'b0, "alu");
        run(6'h00, 1'b1, 1'b1, "alu overflow");
        run(6'h23, 1'b0, 1'b0, "load");
        run(6'h2B, 1'b1, 1'b0, "store");
        run(6'h04, 1'b1, 1'b0, "beq taken");
        run(6'h04, 1'b0, 1'b0, "beq not taken");
        run(6'h02, 1'b0, 1'b1, "jump");
        run(6'h10, 1'b0, 1'b0, "rfe");
        run(6'h3F, 1'b0, 1'b0, "undef 3F");
        run(6'h01, 1'b0, 1'b1, "undef 01");
        for (int k = 0; k < 12; k++) begin
            case (k % 6)
                0: run(6'h23, 1'b0, 1'b1, "mix load");
                1: run(6'h00, 1'b0, k[1], "mix alu");
                2: run(6'h04, k[0], 1'b0, "mix beq");
                3: run(6'h2B, 1'b0, 1'b0, "mix store");
                4: run(6'h11, 1'b0, 1'b0, "mix undef");
                default: run(6'h10, 1'b1, 1'b0, "mix rfe");
            endcase
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule